// File: doc/BRIEF.md
# Counted Loop Branch Unit

This unit carries out the counted conditional loop branches of a 16-bit processor core. A decoded opcode byte, a signed 8-bit displacement, the instruction pointer (already advanced past the branch), the count register and the zero flag arrive on ports together with a one-cycle start pulse. The unit decrements the count and decides whether to branch. It returns the new count, the next instruction pointer, a taken indication and the zero flag, which passes through unchanged.

Three loop forms are recognised. One branches while the flag is clear, one branches while the flag is set, and one ignores the flag. All three branch only if the decremented count is nonzero. The unit then stays busy for a fixed number of cycles that depends on the outcome, so the surrounding pipeline sees the exact cycle cost of each form. Fetch, prefetch and flag generation belong to other blocks.

Top module: `loop_branch_unit`

## Requirements
- R1: On an accepted start, `count_o` becomes `count_i - 1` modulo 2^16, whether or not the branch is taken. A count of 0 gives 0xFFFF.
- R2: Opcode 0xE0 (loop while flag clear) sets `taken_o` only when the decremented count is nonzero and `zf_i` is 0.
- R3: Opcode 0xE1 (loop while flag set) sets `taken_o` only when the decremented count is nonzero and `zf_i` is 1.
- R4: Opcode 0xE2 (plain counted loop) sets `taken_o` whenever the decremented count is nonzero. `zf_i` has no effect on it.
- R5: When taken, `ip_o` is `ip_i` plus `disp_i` sign-extended to 16 bits, modulo 2^16. When not taken, `ip_o` equals `ip_i`.
- R6: `busy_o` rises on the edge that accepts a start. It stays high for exactly 11 cycles for a taken branch and exactly 5 cycles for a not-taken branch.
- R7: `done_o` is high for exactly one cycle, the last cycle of the busy interval. The results are valid from that cycle and stay stable until the next accepted start.
- R8: `zf_o` returns the sampled `zf_i` unchanged: the branch modifies no flag.
- R9: A start pulse while `busy_o` is high is ignored. The interval length and the results of the running operation are unchanged.
- R10: A start with any opcode other than 0xE0, 0xE1 or 0xE2 is ignored. `busy_o` stays low and all result outputs keep their values.
- R11: After reset, `busy_o`, `done_o`, `taken_o` and `zf_o` are 0, and `count_o` and `ip_o` are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to execute the presented branch |
| opcode_i | input | 8 | Decoded opcode byte (0xE0, 0xE1, 0xE2) |
| disp_i | input | 8 | Signed branch displacement |
| ip_i | input | 16 | Instruction pointer past the branch |
| count_i | input | 16 | Current count register |
| zf_i | input | 1 | Current zero flag |
| busy_o | output | 1 | High for the cycle cost of the running branch |
| done_o | output | 1 | High in the final busy cycle |
| taken_o | output | 1 | Branch outcome |
| count_o | output | 16 | Decremented count |
| ip_o | output | 16 | Next instruction pointer |
| zf_o | output | 1 | Zero flag, unchanged |

## Verification
Every cycle, the assertions check the following:
- the busy countdown stays within the longest cost and steps down by one each cycle;
- `done_o` only occurs inside a busy interval, and the interval ends right after it;
- outputs stay stable while idle;
- a taken result never carries a zero count.

Only the bench scenarios can show the things that depend on the values presented at start:
- the condition table of each opcode against the flag and the count;
- the wrap of the count from 0 and of the pointer at both ends of the address space;
- the exact 11 and 5 cycle lengths;
- that starts are refused while busy or with a foreign opcode.

// File: rtl/loop_branch_pkg.sv
package loop_branch_pkg;
    localparam int WORD_W = 16;
    localparam int DISP_W = 8;

    localparam logic [7:0] OP_LOOP_FLAG_CLR = 8'hE0;
    localparam logic [7:0] OP_LOOP_FLAG_SET = 8'hE1;
    localparam logic [7:0] OP_LOOP_PLAIN    = 8'hE2;

    typedef struct packed {
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] ip;
        logic              taken;
        logic              zf;
    } loop_result_t;
endpackage

// File: rtl/loop_cond_eval.sv
module loop_cond_eval #(
    parameter int W        = 16,
    parameter bit PLAIN_EN = 1'b1
) (
    input  logic [7:0]   opcode_i,
    input  logic [W-1:0] count_i,
    input  logic         zf_i,
    output logic [W-1:0] count_dec_o,
    output logic         take_o,
    output logic         legal_o
);
    import loop_branch_pkg::*;

    logic nonzero;
    logic plain_ok;

    generate
        if (PLAIN_EN) begin : g_plain
            assign plain_ok = 1'b1;
        end else begin : g_no_plain
            assign plain_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        count_dec_o = count_i - W'(1);
        nonzero     = |count_dec_o;
        take_o      = 1'b0;
        legal_o     = 1'b0;
        case (opcode_i)
            OP_LOOP_FLAG_CLR: begin
                legal_o = 1'b1;
                take_o  = nonzero & ~zf_i;
            end
            OP_LOOP_FLAG_SET: begin
                legal_o = 1'b1;
                take_o  = nonzero & zf_i;
            end
            OP_LOOP_PLAIN: begin
                legal_o = plain_ok;
                take_o  = nonzero & plain_ok;
            end
            default: begin
                legal_o = 1'b0;
                take_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/loop_target_calc.sv
module loop_target_calc #(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic [W-1:0]  ip_i,
    input  logic [DW-1:0] disp_i,
    output logic [W-1:0]  target_o
);
    logic [W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{(W-DW){disp_i[DW-1]}}, disp_i};
        target_o = ip_i + disp_ext;
    end
endmodule

// File: rtl/loop_cycle_timer.sv
module loop_cycle_timer #(
    parameter int LONG_CYC  = 11,
    parameter int SHORT_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CNT_W = (LONG_CYC > 1) ? $clog2(LONG_CYC) : 1;
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] rem;
    } timer_t;

    timer_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.busy) begin
            if (load_i) begin
                tmr_d.busy = 1'b1;
                tmr_d.rem  = long_i ? LONG_LOAD : SHORT_LOAD;
            end
        end else if (tmr_q.rem == '0) begin
            tmr_d.busy = 1'b0;
        end else begin
            tmr_d.rem = tmr_q.rem - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign last_o = tmr_q.busy && (tmr_q.rem == '0);

    // R6: the countdown never exceeds the longest cost
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.busy |-> (tmr_q.rem <= LONG_LOAD));

    // R9: a running interval keeps counting down, regardless of new loads
    a_r9_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.rem != '0) |=> (tmr_q.busy && tmr_q.rem == $past(tmr_q.rem) - CNT_W'(1)));

    // R7: the interval closes right after its last cycle
    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !tmr_q.busy);
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import loop_branch_pkg::*;
#(
    parameter int  TAKEN_CYC     = 11,
    parameter int  NOT_TAKEN_CYC = 5,
    parameter bit  PLAIN_LOOP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] count_i,
    input  logic              zf_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              taken_o,
    output logic [WORD_W-1:0] count_o,
    output logic [WORD_W-1:0] ip_o,
    output logic              zf_o
);
    logic [WORD_W-1:0] count_dec;
    logic [WORD_W-1:0] target;
    logic              take;
    logic              legal;
    logic              accept;
    logic              busy;
    logic              last;

    loop_result_t res_d, res_q;

    loop_cond_eval #(.W(WORD_W), .PLAIN_EN(PLAIN_LOOP_EN)) u_cond (
        .opcode_i    (opcode_i),
        .count_i     (count_i),
        .zf_i        (zf_i),
        .count_dec_o (count_dec),
        .take_o      (take),
        .legal_o     (legal)
    );

    loop_target_calc #(.W(WORD_W), .DW(DISP_W)) u_target (
        .ip_i     (ip_i),
        .disp_i   (disp_i),
        .target_o (target)
    );

    assign accept = start_i && legal && !busy;

    loop_cycle_timer #(.LONG_CYC(TAKEN_CYC), .SHORT_CYC(NOT_TAKEN_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .long_i (take),
        .busy_o (busy),
        .last_o (last)
    );

    always_comb begin
        res_d = res_q;
        if (accept) begin
            res_d.count = count_dec;
            res_d.ip    = take ? target : ip_i;
            res_d.taken = take;
            res_d.zf    = zf_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign busy_o  = busy;
    assign done_o  = last;
    assign taken_o = res_q.taken;
    assign count_o = res_q.count;
    assign ip_o    = res_q.ip;
    assign zf_o    = res_q.zf;

    // R7: done only inside a busy interval
    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R7: results stay put while nothing new is accepted
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(count_o) && $stable(ip_o) && $stable(taken_o) && $stable(zf_o)));

    // R4: a taken branch always leaves a nonzero count
    a_r4_taken_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && taken_o) |-> (count_o != '0));

    // R10: an unknown opcode never opens a busy interval
    a_r10_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !legal) |=> !busy_o);
endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [7:0]  disp_i = 8'h00;
    logic [15:0] ip_i = 16'h0;
    logic [15:0] count_i = 16'h0;
    logic        zf_i = 1'b0;
    logic        busy_o, done_o, taken_o, zf_o;
    logic [15:0] count_o, ip_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    loop_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .disp_i(disp_i), .ip_i(ip_i), .count_i(count_i), .zf_i(zf_i),
        .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o),
        .count_o(count_o), .ip_o(ip_o), .zf_o(zf_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one branch; optionally fires a second start mid-interval (R9)
    task automatic run_op(input string req, input logic [7:0] op, input logic [7:0] disp,
                          input logic [15:0] ip, input logic [15:0] cnt, input logic zf,
                          input logic exp_taken, input logic poke_mid);
        logic [15:0] exp_cnt, exp_ip;
        int cyc, done_at, done_cnt, exp_cyc;
        logic [15:0] snap_cnt, snap_ip;
        logic snap_tk, snap_zf;
        exp_cnt = cnt - 16'd1;
        exp_ip  = exp_taken ? ip + {{8{disp[7]}}, disp} : ip;
        exp_cyc = exp_taken ? 11 : 5;
        @(negedge clk);
        opcode_i = op; disp_i = disp; ip_i = ip; count_i = cnt; zf_i = zf; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0; done_at = 0; done_cnt = 0;
        snap_cnt = 16'h0; snap_ip = 16'h0; snap_tk = 1'b0; snap_zf = 1'b0;
        while (busy_o && cyc < 40) begin
            cyc++;
            if (done_o) begin
                done_at = cyc; done_cnt++;
                snap_cnt = count_o; snap_ip = ip_o; snap_tk = taken_o; snap_zf = zf_o;
            end
            if (poke_mid && cyc == 2) begin
                opcode_i = 8'hE2; count_i = 16'h0040; ip_i = 16'h1234; zf_i = ~zf; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R6", {req, " busy length"}, cyc, exp_cyc);
        chk("R7", {req, " done position"}, done_at, exp_cyc);
        chk("R7", {req, " done pulses"}, done_cnt, 1);
        chk("R1", {req, " count"}, snap_cnt, exp_cnt);
        chk(req, {req, " taken"}, snap_tk, exp_taken);
        chk("R5", {req, " next ip"}, snap_ip, exp_ip);
        chk("R8", {req, " zf unchanged"}, snap_zf, zf);
        repeat (2) @(negedge clk);
        chk("R7", {req, " held count"}, count_o, exp_cnt);
        chk("R7", {req, " held ip"}, ip_o, exp_ip);
        chk("R7", {req, " held taken"}, taken_o, exp_taken);
    endtask

    task automatic t_reset;
        chk("R11", "busy", busy_o, 0);
        chk("R11", "done", done_o, 0);
        chk("R11", "taken", taken_o, 0);
        chk("R11", "count", count_o, 0);
        chk("R11", "ip", ip_o, 0);
        chk("R11", "zf", zf_o, 0);
    endtask

    task automatic t_illegal(input logic [7:0] op);
        logic [15:0] c0, i0;
        logic t0, z0;
        @(negedge clk);
        c0 = count_o; i0 = ip_o; t0 = taken_o; z0 = zf_o;
        opcode_i = op; count_i = 16'h0009; ip_i = 16'hABCD; disp_i = 8'h05; zf_i = ~z0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10", "busy after foreign opcode", busy_o, 0);
        @(negedge clk);
        chk("R10", "busy later", busy_o, 0);
        chk("R10", "count kept", count_o, c0);
        chk("R10", "ip kept", ip_o, i0);
        chk("R10", "taken kept", taken_o, t0);
        chk("R10", "zf kept", zf_o, z0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // R2 loop while flag clear
        run_op("R2", 8'hE0, 8'h10, 16'h0100, 16'd5, 1'b0, 1'b1, 1'b0);
        run_op("R2", 8'hE0, 8'h10, 16'h0100, 16'd5, 1'b1, 1'b0, 1'b0);
        run_op("R2", 8'hE0, 8'h10, 16'h0100, 16'd1, 1'b0, 1'b0, 1'b0);
        run_op("R2", 8'hE0, 8'hF0, 16'h0200, 16'd0, 1'b0, 1'b1, 1'b0);
        // R3 loop while flag set; negative displacement wraps below zero
        run_op("R3", 8'hE1, 8'h80, 16'h0050, 16'd7, 1'b1, 1'b1, 1'b0);
        run_op("R3", 8'hE1, 8'h80, 16'h0050, 16'd7, 1'b0, 1'b0, 1'b0);
        run_op("R3", 8'hE1, 8'h22, 16'h0300, 16'd1, 1'b1, 1'b0, 1'b0);
        // R4 plain loop ignores the flag
        run_op("R4", 8'hE2, 8'h7F, 16'hFFF0, 16'd3, 1'b1, 1'b1, 1'b0);
        run_op("R4", 8'hE2, 8'h7F, 16'hFFF0, 16'd3, 1'b0, 1'b1, 1'b0);
        run_op("R4", 8'hE2, 8'hFE, 16'h0010, 16'd0, 1'b1, 1'b1, 1'b0);
        run_op("R4", 8'hE2, 8'h04, 16'h0010, 16'd1, 1'b0, 1'b0, 1'b0);
        // R9 start while busy is ignored (both long and short intervals)
        run_op("R9", 8'hE0, 8'h08, 16'h4000, 16'd9, 1'b0, 1'b1, 1'b1);
        run_op("R9", 8'hE1, 8'h08, 16'h4000, 16'd9, 1'b0, 1'b0, 1'b1);
        // R10 foreign opcodes
        t_illegal(8'h90);
        t_illegal(8'hE3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule